// File: doc/BRIEF.md
# Page Program Buffer with Timed Commit

This block stands in for the write side of a byte-wide nonvolatile memory on a parallel bus. The bus has a 15-bit address, an 8-bit data input, and three active-low strobes: chip select, output enable and write enable. The strobes are brought into the system clock domain through two flops each. A write pulse counts only when it stays low for a minimum number of clocks. A qualified write puts one byte into a 64-entry page latch and records which offsets were filled. The page number comes from the first byte of a load, and the offset comes from the low six address bits, so bytes can arrive in any order.

The load closes when no new write pulse starts within a set number of clocks after the last pulse ends. A busy period of fixed length then follows. At its end the whole page in the backing array is replaced: filled offsets get their latched byte and every other offset becomes 0xFF. During the busy period a read does not return stored data. It returns a status byte in which bit 7 is the inverse of bit 7 of the last byte loaded, and bit 6 changes on every new read. Outside the busy period a read returns the array contents through a register. After reset, write pulses are ignored for a set number of clocks.

Top module: `page_prog_buffer`

## Requirements
- R1: A write pulse counts only while the synchronised chip select and write enable are both low and output enable is high. Any write attempt with output enable low, chip select high or write enable high leaves the array unchanged.
- R2: A write pulse that is low for fewer than MIN_LOW clocks after synchronisation is ignored (MIN_LOW is at least 2).
- R3: The address is sampled when the later of the two falling strobes has been low for MIN_LOW clocks. The data input is sampled when the first of the two strobes returns high, as seen after synchronisation. The data must therefore stay stable for at least 4 clocks after that strobe rises.
- R4: Address bits 5:0 give the byte offset within the page. The page number comes from the first byte of a load, and later bytes of the same load go to that page in any order. The array keeps ARRAY_PAGE_W page bits, taken from address bits 6 upward (default: bits 9:6, so 16 pages and 1024 bytes).
- R5: A load ends, and the busy period starts, once LOAD_TIMEOUT clocks pass after the last pulse rose with no new pulse qualified. Until then, reads return stored data.
- R6: The busy period lasts PROG_CYCLES clocks. At its end every offset of the page is written: loaded offsets get their latched byte, and all other offsets get 0xFF.
- R7: A read during the busy period returns a status byte at any address. Bit 7 is the inverse of bit 7 of the last loaded byte, and bits 5:0 equal bits 5:0 of that byte.
- R8: During the busy period, bit 6 of the status byte changes with each new read. It does not change outside the busy period, and reads outside it return stored data.
- R9: Write pulses during the busy period are ignored and do not start a new load.
- R10: For POWER_ON_CYCLES clocks after reset is released, write pulses are ignored.
- R11: After reset, dataOut is 0, dataOe is 0, and every array byte reads 0xFF.
- R12: dataOe is high and dataOut carries data only while chip select and output enable are low and write enable is high. Otherwise dataOe is 0 and dataOut is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ceN | input | 1 | Active-low chip select |
| oeN | input | 1 | Active-low output enable |
| weN | input | 1 | Active-low write enable |
| addr | input | 15 | Byte address; bits 14:6 page, bits 5:0 offset |
| dataIn | input | 8 | Write data |
| dataOut | output | 8 | Read data or busy status byte |
| dataOe | output | 1 | High while dataOut is being driven |

## Verification
The bench writes bytes out of order and with repeated offsets, then reads back the whole page. A design that skipped the 0xFF fill would leave stale bytes, and one that followed later page bits would scatter bytes across pages. Directed cases target the following:
- Staggered strobes, where a design sampling on the wrong edge picks up the junk address or the late data.
- A two-clock glitch and an output-enable-low write, which a weak qualifier would accept.
- A write straight after reset.
- A write during the busy period, which would corrupt the page or start a second cycle.

Status reads are checked just before and just after the timeout, to catch a busy window that opens early. They are also checked twice in a row, to catch a bit 6 that does not change between reads.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOAD,
    ST_PROG
  } pgwState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic captureAddr;
    logic firstByte;
    logic captureData;
    logic commitPage;
    logic busy;
    logic readActive;
    logic readStart;
  } pgwCtl_t;

endpackage

// File: rtl/pgw_ctrl.sv
module pgw_ctrl
  import pgw_pkg::*;
#(
  parameter int MIN_LOW         = 3,
  parameter int LOAD_TIMEOUT    = 48,
  parameter int PROG_CYCLES     = 300,
  parameter int POWER_ON_CYCLES = 40
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    ceN,
  input  logic    oeN,
  input  logic    weN,
  output pgwCtl_t ctl
);

  localparam int LW = $clog2(MIN_LOW + 1);
  localparam int GW = $clog2(LOAD_TIMEOUT + 1);
  localparam int CW = $clog2(PROG_CYCLES + 1);
  localparam int PW = $clog2(POWER_ON_CYCLES + 1);

  logic [1:0] ceSync, oeSync, weSync;
  logic ceS, oeS, weS;
  logic wrLow, rdAct, rdPrev;
  logic [PW-1:0] pwrCnt;
  logic pwrOk;
  logic [LW-1:0] lowCnt;
  logic armed;
  logic fallEv, riseEv;
  logic [GW-1:0] gapCnt;
  logic [CW-1:0] progCnt;
  logic loadTimeout, progDone;
  pgwState_t state;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ceSync <= 2'b11;
      oeSync <= 2'b11;
      weSync <= 2'b11;
    end else begin
      ceSync <= {ceSync[0], ceN};
      oeSync <= {oeSync[0], oeN};
      weSync <= {weSync[0], weN};
    end
  end

  assign ceS   = ceSync[1];
  assign oeS   = oeSync[1];
  assign weS   = weSync[1];
  assign wrLow = !ceS && !weS && oeS;
  assign rdAct = !ceS && !oeS && weS;

  assign pwrOk       = (pwrCnt == PW'(POWER_ON_CYCLES));
  assign fallEv      = wrLow && (lowCnt == LW'(MIN_LOW - 1)) && pwrOk && (state != ST_PROG);
  assign riseEv      = armed && !wrLow;
  assign loadTimeout = (state == ST_LOAD) && !armed && !fallEv && (gapCnt == GW'(LOAD_TIMEOUT - 1));
  assign progDone    = (progCnt == CW'(PROG_CYCLES - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pwrCnt  <= '0;
      lowCnt  <= '0;
      armed   <= 1'b0;
      gapCnt  <= '0;
      progCnt <= '0;
      rdPrev  <= 1'b0;
      state   <= ST_IDLE;
    end else begin
      rdPrev <= rdAct;
      if (!pwrOk) pwrCnt <= pwrCnt + 1'b1;
      if (!wrLow) lowCnt <= '0;
      else if (lowCnt != LW'(MIN_LOW)) lowCnt <= lowCnt + 1'b1;
      if (fallEv) armed <= 1'b1;
      else if (!wrLow) armed <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (fallEv) begin
            state  <= ST_LOAD;
            gapCnt <= '0;
          end
        end
        ST_LOAD: begin
          if (fallEv || riseEv) gapCnt <= '0;
          else if (loadTimeout) begin
            state   <= ST_PROG;
            progCnt <= '0;
          end else if (!armed) gapCnt <= gapCnt + 1'b1;
        end
        ST_PROG: begin
          if (progDone) state <= ST_IDLE;
          else progCnt <= progCnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.captureAddr = fallEv;
    ctl.firstByte   = fallEv && (state == ST_IDLE);
    ctl.captureData = riseEv;
    ctl.commitPage  = (state == ST_PROG) && progDone;
    ctl.busy        = (state == ST_PROG);
    ctl.readActive  = rdAct;
    ctl.readStart   = rdAct && !rdPrev;
  end

  // R9: no capture of any kind while the page is being programmed
  p_busy_blocks_r9: assert property (@(posedge clk) disable iff (!rstN)
    ctl.busy |-> (!ctl.captureAddr && !ctl.captureData));

  // R10: strobes ignored during the power-on hold
  p_pwr_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !pwrOk |-> !ctl.captureAddr);

  // R2: a qualified falling edge needs the strobe low in the previous clock too
  p_min_low_r2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.captureAddr |-> $past(wrLow));

  // R6: the commit pulse ends the busy period
  p_commit_ends_r6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.commitPage |=> (state == ST_IDLE));

endmodule

// File: rtl/pgw_datapath.sv
module pgw_datapath
  import pgw_pkg::*;
#(
  parameter int ADDR_W       = 15,
  parameter int DATA_W       = 8,
  parameter int OFF_W        = 6,
  parameter int ARRAY_PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  pgwCtl_t           ctl,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe
);

  localparam int BYTES     = 1 << OFF_W;
  localparam int IDX_W     = ARRAY_PAGE_W + OFF_W;
  localparam int MEM_DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] pageLatch [BYTES];
  logic [BYTES-1:0]  loadedMask;
  logic [ARRAY_PAGE_W-1:0] pageReg;
  logic [OFF_W-1:0]  curOff;
  logic [DATA_W-1:0] lastByte;
  logic              toggleBit;
  logic [DATA_W-1:0] mem [MEM_DEPTH];
  logic [IDX_W-1:0]  rdIdx;
  logic [DATA_W-1:0] statusByte;
  logic              unusedAddrBits;

  assign unusedAddrBits = ^addr;
  assign rdIdx = {addr[OFF_W +: ARRAY_PAGE_W], addr[OFF_W-1:0]};

  always_comb begin
    statusByte           = lastByte;
    statusByte[DATA_W-1] = ~lastByte[DATA_W-1];
    statusByte[DATA_W-2] = toggleBit;
  end

  // page latch and commit into the array
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loadedMask <= '0;
      pageReg    <= '0;
      curOff     <= '0;
      lastByte   <= '0;
      for (int i = 0; i < BYTES; i++) pageLatch[i] <= '0;
      for (int j = 0; j < MEM_DEPTH; j++) mem[j] <= '1;
    end else begin
      if (ctl.captureAddr) begin
        curOff <= addr[OFF_W-1:0];
        if (ctl.firstByte) pageReg <= addr[OFF_W +: ARRAY_PAGE_W];
      end
      if (ctl.captureData) begin
        pageLatch[curOff]  <= dataIn;
        loadedMask[curOff] <= 1'b1;
        lastByte           <= dataIn;
      end
      if (ctl.commitPage) begin
        for (int k = 0; k < BYTES; k++)
          mem[{pageReg, OFF_W'(k)}] <= loadedMask[k] ? pageLatch[k] : '1;
        loadedMask <= '0;
      end
    end
  end

  // registered read path
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      toggleBit <= 1'b0;
      dataOut   <= '0;
      dataOe    <= 1'b0;
    end else begin
      if (ctl.readStart && ctl.busy) toggleBit <= ~toggleBit;
      dataOe <= ctl.readActive;
      if (!ctl.readActive) dataOut <= '0;
      else if (ctl.busy) dataOut <= statusByte;
      else dataOut <= mem[rdIdx];
    end
  end

  // R8: status toggle frozen outside the busy period
  p_toggle_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.busy |=> $stable(toggleBit));

  // R12: output enable follows the qualified read one clock later
  p_out_quiet_r12: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.readActive |=> (!dataOe && dataOut == '0));

  // R6: commit leaves no offset marked as loaded
  p_commit_clears_r6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.commitPage |=> (loadedMask == '0));

endmodule

// File: rtl/page_prog_buffer.sv
module page_prog_buffer
  import pgw_pkg::*;
#(
  parameter int ADDR_W          = 15,
  parameter int DATA_W          = 8,
  parameter int OFF_W           = 6,
  parameter int ARRAY_PAGE_W    = 4,
  parameter int MIN_LOW         = 3,
  parameter int LOAD_TIMEOUT    = 48,
  parameter int PROG_CYCLES     = 300,
  parameter int POWER_ON_CYCLES = 40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe
);

  pgwCtl_t ctl;

  pgw_ctrl #(
    .MIN_LOW(MIN_LOW),
    .LOAD_TIMEOUT(LOAD_TIMEOUT),
    .PROG_CYCLES(PROG_CYCLES),
    .POWER_ON_CYCLES(POWER_ON_CYCLES)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN), .ctl(ctl)
  );

  pgw_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .OFF_W(OFF_W),
    .ARRAY_PAGE_W(ARRAY_PAGE_W)
  ) uData (
    .clk(clk), .rstN(rstN), .ctl(ctl), .addr(addr), .dataIn(dataIn),
    .dataOut(dataOut), .dataOe(dataOe)
  );

endmodule

// File: tb/sim_page_prog_buffer.sv
module sim_page_prog_buffer;

  localparam int LOAD_TIMEOUT = 48;
  localparam int PROG_CYCLES  = 300;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ceN = 1'b1, oeN = 1'b1, weN = 1'b1;
  logic [14:0] addr = '0;
  logic [7:0] dataIn = '0;
  logic [7:0] dataOut;
  logic dataOe;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [7:0] model [1024];
  logic [7:0] latchM [64];
  bit loadedM [64];

  always #4 clk = ~clk;

  page_prog_buffer #(
    .LOAD_TIMEOUT(LOAD_TIMEOUT),
    .PROG_CYCLES(PROG_CYCLES)
  ) u0 (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN),
    .addr(addr), .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [7:0] statusExp(input logic [7:0] last);
    return {~last[7], 1'b0, last[5:0]};
  endfunction

  task automatic clearLoad();
    for (int i = 0; i < 64; i++) loadedM[i] = 0;
  endtask

  task automatic commitModel(input logic [3:0] pg);
    for (int i = 0; i < 64; i++) begin
      model[{pg, i[5:0]}] = loadedM[i] ? latchM[i] : 8'hFF;
      loadedM[i] = 0;
    end
  endtask

  task automatic writeByte(input logic [14:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; dataIn = d; oeN = 1'b1; ceN = 1'b0; weN = 1'b0;
    tick(5);
    @(negedge clk);
    weN = 1'b1;
    tick(4);
    @(negedge clk);
    ceN = 1'b1;
    tick(2);
  endtask

  task automatic noteByte(input logic [14:0] a, input logic [7:0] d);
    latchM[a[5:0]] = d;
    loadedM[a[5:0]] = 1;
  endtask

  task automatic readByte(input logic [14:0] a, output logic [7:0] r, output logic oe);
    @(negedge clk);
    addr = a; weN = 1'b1; ceN = 1'b0; oeN = 1'b0;
    tick(6);
    @(negedge clk);
    r = dataOut; oe = dataOe;
    oeN = 1'b1; ceN = 1'b1;
    tick(3);
  endtask

  task automatic checkPage(input logic [3:0] pg, input string tag);
    logic [7:0] r;
    logic oe;
    for (int i = 0; i < 64; i++) begin
      readByte({5'd0, pg, i[5:0]}, r, oe);
      chk(tag, r, model[{pg, i[5:0]}]);
    end
  endtask

  initial begin
    logic [7:0] r, r2;
    logic oe;
    logic [7:0] d, last;
    logic [14:0] a;
    logic [3:0] pg;
    int cnt;
    void'($urandom(32'd24681357));
    for (int i = 0; i < 1024; i++) model[i] = 8'hFF;
    clearLoad();
    tick(4);
    @(negedge clk);
    chk("R11 dataOut after reset", dataOut, 8'h00);
    chk("R11 dataOe after reset", {7'd0, dataOe}, 8'h00);
    rstN = 1'b1;

    // R10: write inside power-on hold is dropped
    writeByte(15'h0005, 8'h12);
    tick(LOAD_TIMEOUT + PROG_CYCLES + 20);
    readByte(15'h0005, r, oe);
    chk("R10 write during power-on hold", r, 8'hFF);
    chk("R12 dataOe during read", {7'd0, oe}, 8'h01);
    chk("R11 erased array byte", r, model[10'h005]);

    // R12: chip selected but output enable high
    @(negedge clk);
    ceN = 1'b0; oeN = 1'b1; weN = 1'b1;
    tick(5);
    @(negedge clk);
    chk("R12 dataOe with oe high", {7'd0, dataOe}, 8'h00);
    chk("R12 dataOut with oe high", dataOut, 8'h00);
    ceN = 1'b1;
    tick(3);

    // R4/R6/R7/R8/R9: out-of-order load of page 2
    writeByte(15'h0083, 8'hA7); noteByte(15'h0083, 8'hA7);
    writeByte(15'h00BC, 8'h0E); noteByte(15'h00BC, 8'h0E);
    writeByte(15'h0083, 8'h61); noteByte(15'h0083, 8'h61);
    writeByte(15'h0080, 8'h5A); noteByte(15'h0080, 8'h5A);
    tick(LOAD_TIMEOUT + 5);
    readByte(15'h0123, r, oe);
    chk("R7 busy status bits 7 and 5:0", r & 8'hBF, statusExp(8'h5A));
    readByte(15'h0123, r2, oe);
    chk("R8 bit 6 changes between busy reads", (r ^ r2) & 8'h40, 8'h40);
    writeByte(15'h0081, 8'h33);
    tick(PROG_CYCLES + 20);
    commitModel(4'd2);
    readByte(15'h0081, r, oe);
    chk("R9 write during busy ignored", r, 8'hFF);
    readByte(15'h0081, r2, oe);
    chk("R8 idle reads stable", r2, r);
    checkPage(4'd2, "R6 page 2 contents");
    checkPage(4'd3, "R4 neighbour page untouched");

    // R3: staggered strobes; address at later fall, data at first rise
    @(negedge clk);
    addr = 15'h7FFF; dataIn = 8'hC3; oeN = 1'b1; weN = 1'b0;
    tick(4);
    @(negedge clk);
    addr = 15'h014A; ceN = 1'b0;
    tick(6);
    @(negedge clk);
    ceN = 1'b1;
    tick(5);
    @(negedge clk);
    dataIn = 8'h3C; weN = 1'b1;
    tick(4);
    noteByte(15'h014A, 8'hC3);
    tick(LOAD_TIMEOUT + PROG_CYCLES + 20);
    commitModel(4'd5);
    readByte(15'h014A, r, oe);
    chk("R3 data from first rising strobe at later-fall address", r, 8'hC3);
    readByte(15'h7FFF, r, oe);
    chk("R3 early address not used", r, 8'hFF);
    checkPage(4'd5, "R6 single-byte page fill");

    // R1: output enable low during write strobe
    @(negedge clk);
    addr = 15'h0200; dataIn = 8'h00; ceN = 1'b0; weN = 1'b0; oeN = 1'b0;
    tick(8);
    @(negedge clk);
    ceN = 1'b1; weN = 1'b1; oeN = 1'b1;
    // chip select high during write enable pulse
    tick(3);
    @(negedge clk);
    weN = 1'b0;
    tick(8);
    @(negedge clk);
    weN = 1'b1;
    tick(LOAD_TIMEOUT + PROG_CYCLES + 20);
    readByte(15'h0200, r, oe);
    chk("R1 blocked write strobes", r, 8'hFF);

    // R2: two-clock glitch
    @(negedge clk);
    addr = 15'h0240; dataIn = 8'h00; oeN = 1'b1; ceN = 1'b0; weN = 1'b0;
    tick(2);
    @(negedge clk);
    weN = 1'b1; ceN = 1'b1;
    tick(LOAD_TIMEOUT + PROG_CYCLES + 20);
    readByte(15'h0240, r, oe);
    chk("R2 short strobe ignored", r, 8'hFF);

    // R5: stored data before timeout, status after
    writeByte(15'h01C1, 8'h91); noteByte(15'h01C1, 8'h91);
    readByte(15'h01C1, r, oe);
    chk("R5 stored data before timeout", r, 8'hFF);
    tick(LOAD_TIMEOUT + 5);
    readByte(15'h01C1, r, oe);
    chk("R5 status after timeout", r & 8'hBF, statusExp(8'h91));
    tick(PROG_CYCLES + 20);
    commitModel(4'd7);
    checkPage(4'd7, "R5 committed page");

    // random loads
    for (int round = 0; round < 3; round++) begin
      pg = 4'($urandom_range(8, 15));
      cnt = $urandom_range(1, 64);
      last = 8'h00;
      for (int n = 0; n < cnt; n++) begin
        a = {5'($urandom), pg, 6'($urandom)};
        d = 8'($urandom);
        writeByte(a, d);
        noteByte(a, d);
        last = d;
      end
      tick(LOAD_TIMEOUT + 5);
      readByte(15'h0000, r, oe);
      chk("R7 random busy status", r & 8'hBF, statusExp(last));
      tick(PROG_CYCLES + 20);
      commitModel(pg);
      checkPage(pg, "R6 random page");
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog R5: got hung run expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule